// File: doc/BRIEF.md
# Gated Retriggerable One-Shot Timer

This block is a clocked, synchronous pulse generator that can be retriggered. Each channel has two active-low arm inputs, two active-high enable inputs and an active-low clear. A channel fires when its gated condition changes from false to true. The condition is true when at least one arm input is low, both enable inputs are high and clear is released. Once fired, the output stays high for a programmed number of clock cycles. A new qualifying event during the pulse restarts the timing, so the pulse gets longer. Driving clear low ends the pulse at once.

Every input passes through a two-stage synchronizer. Two programmable windows shape acceptance. The first is a minimum hold: the condition must stay true for a number of cycles before a trigger counts. The second is a lockout window after each accepted trigger, during which further triggers are ignored; a busy output shows that window. The parameter `NUM_CH` sets how many independent channels are built. All channels share the timing settings.

Top module: `gated_oneshot`

## Requirements
- R1: For channel c, the arm inputs are `trig_a_n[2c+1:2c]` and the enable inputs are `trig_b[2c+1:2c]`. A falling edge on one arm input, while both enables and `clr_n[c]` are high, starts a pulse. A rising edge on one enable input, while the other enable is high and at least one arm input is low, also starts a pulse.
- R2: No pulse starts while either enable input of the channel is low, whatever the arm inputs do.
- R3: A condition that stays true produces exactly one pulse. Triggering depends on the false-to-true transition only.
- R4: With `min_hold_cycles` = 0, `pulse_q` rises on the third rising clock edge after an input change. It then stays high for `width_cycles`+1 cycles. A value of 0 gives a one-cycle pulse. The width is captured at the trigger, so later changes to `width_cycles` do not alter a running pulse.
- R5: An accepted trigger that arrives k cycles after the previous accepted trigger, while the pulse is high, restarts the timing. The total high time is then k + `width_cycles` + 1.
- R6: An accepted trigger loads a lockout of `lockout_cycles` cycles, during which `busy` is high. A trigger that arrives k ≤ `lockout_cycles` cycles after the previous accepted one has no effect on the pulse.
- R7: While `clr_n` is low, the output is driven low within three edges and held there, whatever the trigger inputs do. Clear also cancels the lockout.
- R8: A rising edge on `clr_n` starts a pulse when at that moment an arm input is low and both enable inputs are high.
- R9: The gated condition must remain true for `min_hold_cycles`+1 consecutive cycles before a trigger is accepted. The pulse then rises `min_hold_cycles` cycles later than in R4.
- R10: `pulse_qn` is always the bitwise complement of `pulse_q`.
- R11: Synchronous active-high `rst` drives every `pulse_q` low, `pulse_qn` high and `busy` low, even during a pulse.
- R12: Channels are independent: a trigger on one channel leaves the outputs of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| width_cycles | input | CNT_W | Pulse length minus one, in cycles |
| lockout_cycles | input | LOCK_W | Retrigger lockout length in cycles |
| min_hold_cycles | input | HOLD_W | Extra cycles the condition must persist |
| trig_a_n | input | 2*NUM_CH | Active-low arm inputs, two per channel |
| trig_b | input | 2*NUM_CH | Active-high enable inputs, two per channel |
| clr_n | input | NUM_CH | Active-low clear, one per channel |
| pulse_q | output | NUM_CH | Pulse output |
| pulse_qn | output | NUM_CH | Complement of pulse output |
| busy | output | NUM_CH | High while the lockout window counts |

## Verification
The hardest situation to reach is a retrigger that lands inside the lockout window while the pulse is still running. The trigger condition must drop and rise again within a few cycles, measured against a fire moment that sits behind the synchronizer. The stimulus drives a one-cycle arm pulse and a second one a chosen number of cycles later, with a measurement running alongside it. The spacing is picked on each side of the lockout boundary: one spacing is ignored, giving length `width_cycles`+1. The other is accepted, giving the stretched length. Clear-release firing is reached by holding the condition true under clear and then releasing clear.

// File: rtl/osg_pkg.sv
package osg_pkg;
    localparam int DEF_CNT_W  = 16;
    localparam int DEF_LOCK_W = 8;
    localparam int DEF_HOLD_W = 4;
    localparam int SYNC_STAGES = 2;
    localparam int CH_IN_W = 5;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } pulse_st_e;
endpackage

// File: rtl/osg_sync.sv
module osg_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= din;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/osg_qual.sv
module osg_qual #(
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        arm_n,
    input  logic [1:0]        enb,
    input  logic              clr_ok,
    input  logic [HOLD_W-1:0] min_hold,
    output logic              fire
);
    typedef struct packed {
        logic [HOLD_W-1:0] hold;
        logic              done;
    } qual_t;

    qual_t s_d, s_q;
    logic  gate;

    assign gate = (~arm_n[0] | ~arm_n[1]) & enb[0] & enb[1] & clr_ok;

    always_comb begin
        s_d  = s_q;
        fire = 1'b0;
        if (!gate) begin
            s_d.hold = '0;
            s_d.done = 1'b0;
        end else if (!s_q.done) begin
            if (s_q.hold >= min_hold) begin
                fire     = 1'b1;
                s_d.done = 1'b1;
            end else begin
                s_d.hold = s_q.hold + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // R3
    single_fire_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);
endmodule

// File: rtl/osg_core.sv
module osg_core
    import osg_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int LOCK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              clr_ok,
    input  logic [CNT_W-1:0]  width,
    input  logic [LOCK_W-1:0] lockout,
    output logic              q,
    output logic              busy
);
    typedef struct packed {
        pulse_st_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [LOCK_W-1:0] lock;
    } core_t;

    core_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.lock != '0) s_d.lock = s_q.lock - 1'b1;
        if (s_q.st == ST_ACTIVE) begin
            if (s_q.cnt == '0) s_d.st  = ST_IDLE;
            else               s_d.cnt = s_q.cnt - 1'b1;
        end
        if (fire && s_q.lock == '0) begin
            s_d.st   = ST_ACTIVE;
            s_d.cnt  = width;
            s_d.lock = lockout;
        end
        if (!clr_ok) begin
            s_d.st   = ST_IDLE;
            s_d.cnt  = '0;
            s_d.lock = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '{st: ST_IDLE, cnt: '0, lock: '0};
        else     s_q <= s_d;
    end

    assign q    = (s_q.st == ST_ACTIVE);
    assign busy = (s_q.lock != '0);

    // R4
    load_width_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && s_q.lock == '0 && clr_ok) |=> (q && s_q.cnt == $past(width)));
    // R4
    hold_high_chk: assert property (@(posedge clk) disable iff (rst)
        (q && s_q.cnt != '0 && clr_ok) |=> q);
    // R6
    lock_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && busy && q && s_q.cnt != '0 && clr_ok) |=> (s_q.cnt == $past(s_q.cnt) - 1'b1));
    // R7
    clear_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_ok) |=> (!q && !busy));
endmodule

// File: rtl/gated_oneshot.sv
module gated_oneshot
    import osg_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = DEF_CNT_W,
    parameter int LOCK_W = DEF_LOCK_W,
    parameter int HOLD_W = DEF_HOLD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CNT_W-1:0]    width_cycles,
    input  logic [LOCK_W-1:0]   lockout_cycles,
    input  logic [HOLD_W-1:0]   min_hold_cycles,
    input  logic [2*NUM_CH-1:0] trig_a_n,
    input  logic [2*NUM_CH-1:0] trig_b,
    input  logic [NUM_CH-1:0]   clr_n,
    output logic [NUM_CH-1:0]   pulse_q,
    output logic [NUM_CH-1:0]   pulse_qn,
    output logic [NUM_CH-1:0]   busy
);
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            logic [CH_IN_W-1:0] raw, synced;
            logic               fire;

            assign raw = {clr_n[c], trig_b[2*c +: 2], trig_a_n[2*c +: 2]};

            osg_sync #(.W(CH_IN_W), .STAGES(SYNC_STAGES)) i_sync (
                .clk (clk),
                .rst (rst),
                .din (raw),
                .dout(synced)
            );

            osg_qual #(.HOLD_W(HOLD_W)) i_qual (
                .clk     (clk),
                .rst     (rst),
                .arm_n   (synced[1:0]),
                .enb     (synced[3:2]),
                .clr_ok  (synced[4]),
                .min_hold(min_hold_cycles),
                .fire    (fire)
            );

            osg_core #(.CNT_W(CNT_W), .LOCK_W(LOCK_W)) i_core (
                .clk    (clk),
                .rst    (rst),
                .fire   (fire),
                .clr_ok (synced[4]),
                .width  (width_cycles),
                .lockout(lockout_cycles),
                .q      (pulse_q[c]),
                .busy   (busy[c])
            );
        end
    endgenerate

    assign pulse_qn = ~pulse_q;
endmodule

// File: tb/test_gated_oneshot.sv
module test_gated_oneshot;
    localparam int NCH = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [15:0]     width_cycles = 16'd4;
    logic [7:0]      lockout_cycles = 8'd0;
    logic [3:0]      min_hold_cycles = 4'd0;
    logic [2*NCH-1:0] trig_a_n = '1;
    logic [2*NCH-1:0] trig_b = '1;
    logic [NCH-1:0]  clr_n = '1;
    logic [NCH-1:0]  pulse_q, pulse_qn, busy;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    gated_oneshot #(.NUM_CH(NCH)) i_gated_oneshot (
        .clk(clk), .rst(rst), .width_cycles(width_cycles),
        .lockout_cycles(lockout_cycles), .min_hold_cycles(min_hold_cycles),
        .trig_a_n(trig_a_n), .trig_b(trig_b), .clr_n(clr_n),
        .pulse_q(pulse_q), .pulse_qn(pulse_qn), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // counts negedges until q of channel rises (delay) and then while high (len)
    task automatic measure(input int ch, input int limit, output int dly, output int len);
        dly = 0; len = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            dly++;
            if (pulse_q[ch]) break;
        end
        if (!pulse_q[ch]) begin dly = -1; return; end
        while (pulse_q[ch] && len < 1000) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic arm_pulse(input int ch, input int cycles);
        trig_a_n[2*ch] = 1'b0;
        idle(cycles);
        trig_a_n[2*ch] = 1'b1;
    endtask

    task automatic t_reset;
        check(pulse_q == '0, "R11 q after reset", pulse_q, 0);
        check(pulse_qn == '1, "R11 qn after reset", pulse_qn, 3);
        check(busy == '0, "R11 busy after reset", busy, 0);
    endtask

    task automatic t_arm_edge;
        int d, l;
        width_cycles = 16'd4;
        fork
            arm_pulse(0, 1);
            measure(0, 20, d, l);
        join
        check(d == 3, "R1/R4 arm edge delay", d, 3);
        check(l == 5, "R4 width", l, 5);
        idle(4);
    endtask

    task automatic t_zero_width;
        int d, l;
        width_cycles = 16'd0;
        fork
            arm_pulse(0, 1);
            measure(0, 20, d, l);
        join
        check(l == 1, "R4 zero width one cycle", l, 1);
        idle(4);
    endtask

    task automatic t_enable_edge;
        int d, l;
        width_cycles = 16'd3;
        trig_b[0] = 1'b0;
        trig_a_n[1] = 1'b0;
        idle(5);
        check(pulse_q[0] == 1'b0, "R2 no pulse with enable low", pulse_q[0], 0);
        fork
            begin trig_b[0] = 1'b1; end
            measure(0, 20, d, l);
        join
        check(d == 3 && l == 4, "R1 enable rising edge", d*100+l, 304);
        idle(20);
        check(pulse_q[0] == 1'b0, "R3 steady level no refire", pulse_q[0], 0);
        trig_a_n[1] = 1'b1;
        idle(4);
    endtask

    task automatic t_enable_low_blocks;
        int d, l;
        trig_b[1] = 1'b0;
        fork
            arm_pulse(0, 2);
            measure(0, 15, d, l);
        join
        check(d == -1, "R2 arm edge ignored, enable low", d, -1);
        trig_b[1] = 1'b1;
        idle(4);
    endtask

    task automatic t_level_once;
        int rises = 0;
        bit prev = 1'b0;
        width_cycles = 16'd2;
        trig_a_n[0] = 1'b0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (pulse_q[0] && !prev) rises++;
            prev = pulse_q[0];
        end
        check(rises == 1, "R3 one pulse per level", rises, 1);
        trig_a_n[0] = 1'b1;
        idle(4);
    endtask

    task automatic t_width_sampled;
        int d, l;
        width_cycles = 16'd6;
        fork
            arm_pulse(0, 1);
            begin idle(5); width_cycles = 16'd20; end
            measure(0, 20, d, l);
        join
        check(l == 7, "R4 width captured at trigger", l, 7);
        width_cycles = 16'd6;
        idle(4);
    endtask

    task automatic t_retrigger(input int lock, input int k, input int exp_len, input string req);
        int d, l;
        width_cycles = 16'd20;
        lockout_cycles = 8'(lock);
        fork
            begin arm_pulse(0, 1); idle(k-1); arm_pulse(0, 1); end
            measure(0, 20, d, l);
        join
        check(l == exp_len, req, l, exp_len);
        idle(8);
    endtask

    task automatic t_busy;
        int cnt = 0;
        width_cycles = 16'd2;
        lockout_cycles = 8'd5;
        arm_pulse(0, 1);
        idle(1);
        for (int i = 0; i < 12; i++) begin
            if (busy[0]) cnt++;
            @(negedge clk);
        end
        check(cnt == 5, "R6 busy length", cnt, 5);
        lockout_cycles = 8'd0;
        idle(4);
    endtask

    task automatic t_clear;
        int d, l;
        width_cycles = 16'd40;
        lockout_cycles = 8'd50;
        arm_pulse(0, 1);
        idle(6);
        check(pulse_q[0] == 1'b1 && busy[0] == 1'b1, "R7 pulse running", pulse_q[0], 1);
        clr_n[0] = 1'b0;
        idle(3);
        check(pulse_q[0] == 1'b0, "R7 clear ends pulse", pulse_q[0], 0);
        check(busy[0] == 1'b0, "R7 clear cancels lockout", busy[0], 0);
        check(pulse_qn[0] == 1'b1, "R10 qn under clear", pulse_qn[0], 1);
        arm_pulse(0, 2);
        trig_b[0] = 1'b0; idle(2); trig_b[0] = 1'b1;
        idle(5);
        check(pulse_q[0] == 1'b0, "R7 triggers ignored under clear", pulse_q[0], 0);
        width_cycles = 16'd3;
        lockout_cycles = 8'd0;
        trig_a_n[1] = 1'b0;
        idle(3);
        fork
            begin clr_n[0] = 1'b1; end
            measure(0, 20, d, l);
        join
        check(d == 3 && l == 4, "R8 clear release fires", d*100+l, 304);
        trig_a_n[1] = 1'b1;
        idle(4);
    endtask

    task automatic t_min_hold;
        int d, l;
        width_cycles = 16'd2;
        min_hold_cycles = 4'd3;
        fork
            arm_pulse(0, 3);
            measure(0, 15, d, l);
        join
        check(d == -1, "R9 short condition rejected", d, -1);
        idle(3);
        fork
            arm_pulse(0, 4);
            measure(0, 20, d, l);
        join
        check(d == 6 && l == 3, "R9 held condition accepted", d*100+l, 603);
        min_hold_cycles = 4'd0;
        idle(4);
    endtask

    task automatic t_channels;
        int d, l;
        bit other = 1'b0;
        width_cycles = 16'd5;
        fork
            arm_pulse(1, 1);
            measure(1, 20, d, l);
            begin
                for (int i = 0; i < 12; i++) begin
                    @(negedge clk);
                    if (pulse_q[0]) other = 1'b1;
                end
            end
        join
        check(d == 3 && l == 6, "R12 channel 1 pulse", d*100+l, 306);
        check(other == 1'b0, "R12 channel 0 untouched", other, 0);
        check(pulse_qn == ~pulse_q, "R10 complement", pulse_qn, ~pulse_q);
        idle(4);
    endtask

    task automatic t_reset_mid;
        width_cycles = 16'd30;
        arm_pulse(0, 1);
        idle(4);
        rst = 1'b1;
        idle(1);
        check(pulse_q[0] == 1'b0 && busy[0] == 1'b0, "R11 reset mid pulse", pulse_q[0], 0);
        rst = 1'b0;
        idle(4);
    endtask

    initial begin
        #400000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_arm_edge();
        t_zero_width();
        t_enable_edge();
        t_enable_low_blocks();
        t_level_once();
        t_width_sampled();
        t_retrigger(0, 5, 26, "R5 retrigger stretches");
        t_retrigger(6, 3, 21, "R6 retrigger in lockout ignored");
        t_retrigger(6, 8, 29, "R5/R6 retrigger after lockout");
        t_busy();
        t_clear();
        t_min_hold();
        t_channels();
        t_reset_mid();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule